// File: doc/BRIEF.md
# ALU Branch-Condition Unit with Freeze

This block sits beside a 16-bit ALU and keeps the condition flags of its last operation so that the next microinstruction can branch on them without waiting for the ALU again. At each rising clock edge it records four flags from the ALU outputs. The zero and negative flags are derived from the result, and the carry and signed overflow arrive as their own inputs. A select code, together with a sense bit, then picks one condition. The condition can be one of the recorded flags, a live input such as the sign or low bit of the R-bus, the count register's zero test, the "no I/O attention" line, or a reschedule flag that is set and cleared by its own control inputs.

A freeze input, asserted for one instruction, stops the zero, negative and carry flags from being updated at that edge. They then keep the values recorded before the instruction, whatever the ALU produces. The overflow flag keeps updating. Selecting the count test also raises a decrement strobe toward the count register. Reset is asynchronous and active low. Its release passes through a two-stage synchronizer.

Top module: `bcu_branch_cond`

## Requirements
- R1: Driving rst_n low clears all four ALU flags and the reschedule flag at once, without waiting for a clock edge. After rst_n rises, flags begin to be recorded from the third rising edge onward.
- R2: Code 0 (zero) is taken when every one of the 16 bits of the result recorded at the last update was 0. Code 1 (negative) is taken when bit 15 of that result was 1.
- R3: Code 2 (carry) returns the recorded alu_cout. The ALU forms a subtraction as A + ~B + 1, so, for example, 0xFFFF-1 gives carry 1 and 0-1 gives carry 0.
- R4: Code 7 (overflow) returns alu_ovf as recorded at the last rising edge. This flag updates at every edge, whether or not freeze is asserted.
- R5: When freeze_i is high at a rising edge, the zero, negative and carry flags keep their previous values at that edge.
- R6: At a rising edge where freeze_i is low, the zero, negative and carry flags take the fresh ALU values, so the next branch sees the new operation.
- R7: Code 3 (count zero) returns cnt_is_zero. cnt_dec is high exactly when code 3 is on cond_sel, in either sense.
- R8: Code 4 (R negative) returns rbus_sign and code 5 (R odd) returns rbus_lsb. Both follow these inputs in the same cycle, and freeze has no effect on them.
- R9: A resched_set pulse makes code 6 true from the next edge on. A resched_clr pulse makes it false, and clear wins when both are high. The reschedule flag changes no other condition.
- R10: Code 8 (no I/O attention) is taken when io_attn is low.
- R11: For codes 0 to 8, cond_inv high inverts the condition.
- R12: Codes 9 to 15 are never taken in either sense, and they leave cnt_dec low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_res | input | 16 | ALU result of the current instruction |
| alu_cout | input | 1 | ALU carry-out of the current instruction |
| alu_ovf | input | 1 | ALU signed overflow of the current instruction |
| freeze_i | input | 1 | Hold zero, negative and carry flags at this edge |
| cnt_is_zero | input | 1 | Count register equals zero |
| rbus_sign | input | 1 | R-bus bit 15 |
| rbus_lsb | input | 1 | R-bus bit 0 |
| resched_set | input | 1 | Set reschedule flag |
| resched_clr | input | 1 | Clear reschedule flag (priority) |
| io_attn | input | 1 | I/O attention request |
| cond_sel | input | 4 | Condition code 0..8, others unused |
| cond_inv | input | 1 | Invert the selected condition |
| take | output | 1 | Selected branch condition |
| cnt_dec | output | 1 | Decrement strobe for the count register |

## Verification
The flags from an ALU operation, the freeze decision and the reschedule pulses take effect at the first rising edge after they are driven, so their effect on take is due in the cycle after. The R-bus bits, the count test, the I/O line, the select code and the sense bit reach take and cnt_dec in the same cycle, through logic alone. The bench drives inputs on the falling edge and compares against its model 1 ns later. It advances the model's recorded flags only after the rising edge. An asynchronous reset is checked 1 ns after rst_n falls, with no edge in between.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  localparam int DW    = 16;
  localparam int NFLAG = 4;
  // flag vector positions
  localparam int F_ZERO  = 0;
  localparam int F_NEG   = 1;
  localparam int F_CARRY = 2;
  localparam int F_OVF   = 3;
  // flags held by freeze: zero, negative, carry
  localparam logic [NFLAG-1:0] HOLD_MASK = 4'b0111;

  typedef enum logic [3:0] {
    C_ZERO  = 4'd0,
    C_NEG   = 4'd1,
    C_CARRY = 4'd2,
    C_CNTZ  = 4'd3,
    C_RNEG  = 4'd4,
    C_RODD  = 4'd5,
    C_RESCH = 4'd6,
    C_OVF   = 4'd7,
    C_NOIO  = 4'd8
  } cond_e;
endpackage

// File: rtl/bcu_rst_sync.sv
module bcu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_q = sh_q[STAGES-1];
endmodule

// File: rtl/bcu_flag_bank.sv
module bcu_flag_bank #(
  parameter int N = bcu_pkg::NFLAG,
  parameter logic [N-1:0] HOLD = bcu_pkg::HOLD_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] en;
  logic [N-1:0] nxt;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (HOLD[i]) begin : g_hold
      assign en[i] = ~freeze;
    end else begin : g_free
      assign en[i] = 1'b1;
    end
    assign nxt[i] = en[i] ? d[i] : q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/bcu_resched.sv
module bcu_resched (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i)      flag_d = 1'b0;
    else if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/bcu_cond_mux.sv
module bcu_cond_mux
  import bcu_pkg::*;
(
  input  logic [NFLAG-1:0] flags,
  input  logic             cnt_is_zero,
  input  logic             rbus_sign,
  input  logic             rbus_lsb,
  input  logic             resched,
  input  logic             io_attn,
  input  logic [3:0]       sel,
  input  logic             inv,
  output logic             take,
  output logic             cnt_dec
);
  logic raw;
  logic known;

  always_comb begin
    raw   = 1'b0;
    known = 1'b1;
    case (sel)
      C_ZERO:  raw = flags[F_ZERO];
      C_NEG:   raw = flags[F_NEG];
      C_CARRY: raw = flags[F_CARRY];
      C_CNTZ:  raw = cnt_is_zero;
      C_RNEG:  raw = rbus_sign;
      C_RODD:  raw = rbus_lsb;
      C_RESCH: raw = resched;
      C_OVF:   raw = flags[F_OVF];
      C_NOIO:  raw = ~io_attn;
      default: known = 1'b0;
    endcase
    take    = known & (raw ^ inv);
    cnt_dec = (sel == C_CNTZ);
  end
endmodule

// File: rtl/bcu_branch_cond.sv
module bcu_branch_cond
  import bcu_pkg::*;
#(
  parameter int DATA_W = DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_cout,
  input  logic              alu_ovf,
  input  logic              freeze_i,
  input  logic              cnt_is_zero,
  input  logic              rbus_sign,
  input  logic              rbus_lsb,
  input  logic              resched_set,
  input  logic              resched_clr,
  input  logic              io_attn,
  input  logic [3:0]        cond_sel,
  input  logic              cond_inv,
  output logic              take,
  output logic              cnt_dec
);
  localparam int MSB = DATA_W - 1;

  logic             rst_q;
  logic [NFLAG-1:0] flag_d;
  logic [NFLAG-1:0] flag_q;
  logic             resched_q;

  bcu_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  always_comb begin
    flag_d          = '0;
    flag_d[F_ZERO]  = ~|alu_res;
    flag_d[F_NEG]   = alu_res[MSB];
    flag_d[F_CARRY] = alu_cout;
    flag_d[F_OVF]   = alu_ovf;
  end

  bcu_flag_bank #(.N(NFLAG), .HOLD(HOLD_MASK)) u_flags (
    .clk    (clk),
    .rst_n  (rst_q),
    .freeze (freeze_i),
    .d      (flag_d),
    .q      (flag_q)
  );

  bcu_resched u_resch (
    .clk    (clk),
    .rst_n  (rst_q),
    .set_i  (resched_set),
    .clr_i  (resched_clr),
    .flag_q (resched_q)
  );

  bcu_cond_mux u_mux (
    .flags       (flag_q),
    .cnt_is_zero (cnt_is_zero),
    .rbus_sign   (rbus_sign),
    .rbus_lsb    (rbus_lsb),
    .resched     (resched_q),
    .io_attn     (io_attn),
    .sel         (cond_sel),
    .inv         (cond_inv),
    .take        (take),
    .cnt_dec     (cnt_dec)
  );
endmodule

// File: rtl/bcu_checker.sv
module bcu_checker
  import bcu_pkg::*;
(
  input logic             clk,
  input logic             rst_q,
  input logic [DW-1:0]    alu_res,
  input logic             alu_cout,
  input logic             alu_ovf,
  input logic             freeze_i,
  input logic [NFLAG-1:0] flag_q,
  input logic             resched_q,
  input logic             resched_set,
  input logic             resched_clr,
  input logic             rbus_lsb,
  input logic [3:0]       cond_sel,
  input logic             cond_inv,
  input logic             take,
  input logic             cnt_dec
);
  assert_zero_capture_R2: assert property (@(posedge clk) disable iff (!rst_q)
    !freeze_i |=> flag_q[F_ZERO] == ($past(alu_res) == '0));

  assert_carry_capture_R3: assert property (@(posedge clk) disable iff (!rst_q)
    !freeze_i |=> flag_q[F_CARRY] == $past(alu_cout));

  assert_no_overflow_hold_R4: assert property (@(posedge clk) disable iff (!rst_q)
    freeze_i |=> flag_q[F_OVF] == $past(alu_ovf));

  assert_freeze_hold_R5: assert property (@(posedge clk) disable iff (!rst_q)
    freeze_i |=> $stable(flag_q[F_CARRY:F_ZERO]));

  assert_cnt_dec_R7: assert property (@(posedge clk) disable iff (!rst_q)
    cnt_dec |-> cond_sel == C_CNTZ);

  assert_rodd_live_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (cond_sel == C_RODD && !cond_inv) |-> take == rbus_lsb);

  assert_resched_clr_R9: assert property (@(posedge clk) disable iff (!rst_q)
    resched_clr |=> !resched_q);

  assert_resched_set_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (resched_set && !resched_clr) |=> resched_q);

  assert_unused_code_R12: assert property (@(posedge clk) disable iff (!rst_q)
    (cond_sel > 4'd8) |-> !take);
endmodule

bind bcu_branch_cond bcu_checker u_chk (
  .clk         (clk),
  .rst_q       (rst_q),
  .alu_res     (alu_res),
  .alu_cout    (alu_cout),
  .alu_ovf     (alu_ovf),
  .freeze_i    (freeze_i),
  .flag_q      (flag_q),
  .resched_q   (resched_q),
  .resched_set (resched_set),
  .resched_clr (resched_clr),
  .rbus_lsb    (rbus_lsb),
  .cond_sel    (cond_sel),
  .cond_inv    (cond_inv),
  .take        (take),
  .cnt_dec     (cnt_dec)
);

// File: tb/sim_bcu_branch_cond.sv
`timescale 1ns/1ps
module sim_bcu_branch_cond;
  logic        clk;
  logic        rst_n;
  logic [15:0] alu_res;
  logic        alu_cout, alu_ovf, freeze_i, cnt_is_zero;
  logic        rbus_sign, rbus_lsb, resched_set, resched_clr, io_attn;
  logic [3:0]  cond_sel;
  logic        cond_inv;
  logic        take, cnt_dec;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  // reference model state
  int mz = 0, mn = 0, mc = 0, mo = 0, mr = 0;

  bcu_branch_cond u0 (
    .clk(clk), .rst_n(rst_n), .alu_res(alu_res), .alu_cout(alu_cout),
    .alu_ovf(alu_ovf), .freeze_i(freeze_i), .cnt_is_zero(cnt_is_zero),
    .rbus_sign(rbus_sign), .rbus_lsb(rbus_lsb), .resched_set(resched_set),
    .resched_clr(resched_clr), .io_attn(io_attn), .cond_sel(cond_sel),
    .cond_inv(cond_inv), .take(take), .cnt_dec(cnt_dec)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit model_take();
    int r;
    r = -1;
    case (cond_sel)
      4'd0: r = mz;
      4'd1: r = mn;
      4'd2: r = mc;
      4'd3: r = cnt_is_zero;
      4'd4: r = rbus_sign;
      4'd5: r = rbus_lsb;
      4'd6: r = mr;
      4'd7: r = mo;
      4'd8: r = !io_attn;
      default: r = -1;
    endcase
    if (r < 0) return 1'b0;
    return (r != 0) ^ cond_inv;
  endfunction

  task automatic check(input bit act, input bit exp, input string tag, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b (sel=%0d inv=%0b)",
               tag, what, act, exp, cond_sel, cond_inv);
    end
  endtask

  // called just after a falling edge with inputs driven
  task automatic cyc(input string tag, input int lit = -1);
    #1;
    check(take, model_take(), tag, "take vs model");
    check(cnt_dec, cond_sel == 4'd3, tag, "cnt_dec");
    if (lit >= 0) check(take, lit[0], tag, "take vs expected");
    @(posedge clk);
    if (!freeze_i) begin
      mz = (alu_res == 16'h0);
      mn = alu_res[15];
      mc = alu_cout;
    end
    mo = alu_ovf;
    if (resched_clr) mr = 0;
    else if (resched_set) mr = 1;
    @(negedge clk);
  endtask

  task automatic alu(input logic [15:0] a, input logic [15:0] b, input bit sub);
    logic [15:0] bb;
    logic [16:0] s;
    bb = sub ? ~b : b;
    s = {1'b0, a} + {1'b0, bb} + {16'h0, sub};
    alu_res  = s[15:0];
    alu_cout = s[16];
    alu_ovf  = (a[15] == bb[15]) && (s[15] != a[15]);
  endtask

  // operation at one edge, then test the code in the next cycle
  task automatic op_test(input logic [15:0] a, input logic [15:0] b, input bit sub,
                         input logic [3:0] code, input bit inv, input int lit,
                         input string tag);
    alu(a, b, sub);
    freeze_i = 1'b0;
    cond_sel = 4'd15;
    cond_inv = 1'b0;
    cyc(tag);
    cond_sel = code;
    cond_inv = inv;
    cyc(tag, lit);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    alu_res = 16'h0; alu_cout = 0; alu_ovf = 0; freeze_i = 0;
    cnt_is_zero = 0; rbus_sign = 0; rbus_lsb = 0;
    resched_set = 0; resched_clr = 0; io_attn = 0;
    cond_sel = 4'd0; cond_inv = 0;
    repeat (3) @(negedge clk);
    release_reset();

    // R1 reset state
    cond_sel = 4'd0; cyc("R1", 0);
    cond_sel = 4'd6; cyc("R1", 0);

    // R2 zero flag sees every bit, negative from bit 15
    for (int i = 0; i < 16; i++) begin
      alu_res = 16'h1 << i; alu_cout = 0; alu_ovf = 0;
      cond_sel = 4'd15; cyc("R2");
      cond_sel = 4'd0; cyc("R2", 0);
    end
    op_test(16'h0, 16'h0, 0, 4'd0, 0, 1, "R2");
    op_test(16'h8000, 16'h0, 0, 4'd1, 0, 1, "R2");
    op_test(16'h7FFF, 16'h0, 0, 4'd1, 0, 0, "R2");

    // R3 carry
    op_test(16'hFFFF, 16'h0001, 0, 4'd2, 0, 1, "R3");
    op_test(16'hFFFF, 16'h8000, 0, 4'd2, 0, 1, "R3");
    op_test(16'h8000, 16'h8000, 0, 4'd2, 0, 1, "R3");
    op_test(16'h5555, 16'hAAAA, 0, 4'd2, 0, 0, "R3");
    op_test(16'h7FFF, 16'h0000, 0, 4'd2, 0, 0, "R3");
    op_test(16'hFFFF, 16'h0001, 1, 4'd2, 0, 1, "R3");
    op_test(16'h8000, 16'h5555, 1, 4'd2, 0, 1, "R3");
    op_test(16'h0000, 16'h0001, 1, 4'd2, 0, 0, "R3");
    op_test(16'h0000, 16'hAAAA, 1, 4'd2, 0, 0, "R3");

    // R4 overflow
    op_test(16'h4000, 16'h4000, 0, 4'd7, 0, 1, "R4");
    op_test(16'h8000, 16'h8000, 0, 4'd7, 0, 1, "R4");
    op_test(16'h8000, 16'hC000, 0, 4'd7, 0, 1, "R4");
    op_test(16'hC000, 16'h8000, 0, 4'd7, 0, 1, "R4");
    op_test(16'hC000, 16'hC000, 0, 4'd7, 0, 0, "R4");
    op_test(16'h4000, 16'hC000, 0, 4'd7, 0, 0, "R4");
    op_test(16'h4000, 16'h0000, 0, 4'd7, 0, 0, "R4");

    // R5 freeze: record carry=1 zero=1
    alu(16'hFFFF, 16'h0001, 0); freeze_i = 0; cond_sel = 4'd15; cyc("R5");
    alu(16'h0001, 16'h0001, 0); freeze_i = 1; cond_sel = 4'd2; cyc("R5", 1);
    alu(16'h4000, 16'h4000, 0); freeze_i = 1; cond_sel = 4'd0; cyc("R5", 1);
    cond_sel = 4'd7; cyc("R4", 1);
    cond_sel = 4'd1; cyc("R5", 0);
    rbus_sign = 1; rbus_lsb = 1;
    cond_sel = 4'd4; cyc("R8", 1);
    cond_sel = 4'd5; cond_inv = 1; cyc("R8", 0);
    cond_inv = 0; rbus_lsb = 0; cyc("R8", 0);
    // R6 release
    alu(16'h0001, 16'h0000, 0); freeze_i = 0; cond_sel = 4'd0; cyc("R5", 1);
    cond_sel = 4'd0; cyc("R6", 0);
    cond_sel = 4'd2; cyc("R6", 0);

    // R7 count test
    cnt_is_zero = 1; cond_sel = 4'd3; cyc("R7", 1);
    cnt_is_zero = 0; cyc("R7", 0);
    cond_inv = 1; cyc("R7", 1);
    cond_inv = 0;

    // R9 reschedule
    resched_set = 1; cond_sel = 4'd6; cyc("R9", 0);
    resched_set = 0; cyc("R9", 1);
    cond_inv = 1; cyc("R9", 0);
    cond_inv = 0;
    op_test(16'hFFFF, 16'h0001, 1, 4'd2, 0, 1, "R9");
    op_test(16'h0000, 16'h0001, 1, 4'd2, 0, 0, "R9");
    op_test(16'h0000, 16'h0000, 0, 4'd0, 0, 1, "R9");
    resched_set = 1; resched_clr = 1; cond_sel = 4'd6; cyc("R9", 1);
    resched_set = 0; resched_clr = 0; cyc("R9", 0);

    // R10 I/O attention
    io_attn = 0; cond_sel = 4'd8; cyc("R10", 1);
    io_attn = 1; cyc("R10", 0);

    // R11 inverted sense
    op_test(16'h0000, 16'h0000, 0, 4'd0, 1, 0, "R11");
    op_test(16'h0001, 16'h0000, 0, 4'd0, 1, 1, "R11");
    op_test(16'h8000, 16'h0000, 0, 4'd1, 1, 0, "R11");
    rbus_sign = 0; cond_sel = 4'd4; cond_inv = 1; cyc("R11", 1);
    cond_inv = 0;

    // R12 unused codes
    for (int c = 9; c < 16; c++) begin
      cnt_is_zero = 1; io_attn = 0;
      cond_sel = 4'(c); cond_inv = 0; cyc("R12", 0);
      cond_inv = 1; cyc("R12", 0);
    end
    cond_inv = 0;

    // R1 asynchronous reset mid-run
    resched_set = 1; alu(16'h0000, 16'h0000, 0); cond_sel = 4'd15; cyc("R1");
    resched_set = 0; cond_sel = 4'd6; cyc("R1", 1);
    rst_n = 1'b0;
    mz = 0; mn = 0; mc = 0; mo = 0; mr = 0;
    #1;
    check(take, 1'b0, "R1", "reschedule after async reset");
    cond_sel = 4'd0; #0.5;
    check(take, 1'b0, "R1", "zero flag after async reset");
    @(negedge clk);
    release_reset();
    cond_sel = 4'd0; cyc("R1", 0);
    cond_sel = 4'd0; cyc("R1", 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule